// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small microcontroller core: two active-low external pins, two timer overflow events and a serial port with separate receive and transmit events. Each source sets a pending flag. The flags are masked by per-source enable bits and a global enable bit. They are then split into a high level and a low level by a priority register. Within each level, a fixed polling order picks one winner. The block presents the winner's vector address and a request line to the CPU.

The CPU sends a one-cycle acknowledge pulse to take the presented vector. The acknowledge marks the winner's level as in service. It also clears the winning flag, but only for sources that hardware clears: the timers always, and the external pins only in edge mode. The external pins pass through a synchronizer first. The serial flags are cleared only by software. A return pulse releases the highest level that is in service, so nested service unwinds correctly. A small register port gives software read and write access to the flags, the trigger modes, the enables and the priorities. Writing the flags has the same effect as the hardware events, so software can raise or cancel requests.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_req_o` is low.
- R2: Register addresses are as follows. Address 0 holds the pending flags: bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial receive, bit5 serial transmit. Address 1 holds the trigger modes: bit0 ext0, bit1 ext1, where 1 means edge mode. Address 2 holds the enables: bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 serial, bit7 global. Address 3 holds the priorities, one bit per source in the same order as the enables, where 1 means high. Bits 5 and 6 of the enable register always read 0.
- R3: In edge mode, a falling transition on an external pin sets its flag. The flag becomes visible SYNC_STAGES+1 clock edges after the pin falls. An acknowledge of that source's vector clears the flag, even if the pin is still low.
- R4: In level mode, an external flag reads as the inverse of the synchronized pin. An acknowledge does not clear it. It drops only when the pin returns high.
- R5: A timer overflow pulse sets that timer's flag. An acknowledge of the timer's vector clears the flag.
- R6: The serial request is the OR of the receive flag and the transmit flag. An acknowledge clears neither flag.
- R7: A write to address 0 sets or clears each flag exactly as the hardware events do. This raises or cancels requests.
- R8: A source requests only when both its own enable bit and the global enable bit are set. A disabled source still records its flag.
- R9: The vector is 0x0003 + 8*index. The index order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4. When several sources of the same level are pending, the lowest index wins.
- R10: When pending requests exist at both levels, a high-level request wins over any low-level request.
- R11: While a low-level service is active, only high-level requests are presented. While a high-level service is active, no request is presented.
- R12: A return pulse clears the high in-service level if it is active, and otherwise clears the low in-service level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext0_ni | input | 1 | External request pin 0, active low |
| ext1_ni | input | 1 | External request pin 1, active low |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| ser_rx_i | input | 1 | Serial receive-done pulse |
| ser_tx_i | input | 1 | Serial transmit-done pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_req_o | output | 1 | A vector is presented |
| irq_vec_o | output | 16 | Vector address of the current winner |
| irq_ack_i | input | 1 | CPU takes the presented vector |
| irq_ret_i | input | 1 | CPU returns from service |

## Verification
The hardest state to reach from the ports is two nested services: a low-level service preempted by a high-level request, and then two returns that must unwind in the right order. The bench builds this state from flags written through the register port, with both external pins in edge mode so the written flags stay put. It takes a low-level timer vector first. It then raises a high-level timer flag under it and takes that vector too. It then checks that the first return leaves the low level blocking a pending low request, and that the second return releases it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_EN   = 2'd2;
  localparam logic [1:0] ADDR_PRIO = 2'd3;

  localparam int EN_GLOBAL = 7;

  typedef struct packed {
    logic hi;
    logic lo;
  } isr_t;
endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, prev_q, flag_q, fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (sw_we_i)     flag_q <= sw_val_i;
    else if (!edge_mode_i) flag_q <= ~pin_s;
    else if (fall)        flag_q <= 1'b1;
    else if (clr_i)       flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && fall && !sw_we_i) |=> flag_q);
  // R3
  edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && clr_i && !fall && !sw_we_i) |=> !flag_q);
  // R4
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !sw_we_i) |=> (flag_q == !$past(pin_s)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  prio_i,
  input  isr_t             isr_i,
  output logic             valid_o,
  output logic             lvl_hi_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NSRC-1:0]  grant_o
);
  logic [NSRC-1:0] hi_req, lo_req, pick;
  logic hi_any, lo_any;

  assign hi_req = isr_i.hi ? '0 : (req_i & prio_i);
  assign lo_req = (isr_i.hi || isr_i.lo) ? '0 : (req_i & ~prio_i);
  assign hi_any = |hi_req;
  assign lo_any = |lo_req;
  assign pick   = hi_any ? hi_req : lo_req;

  // lowest index wins inside a level
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) begin
        idx_o   = IDX_W'(i);
        grant_o = NSRC'(1) << i;
      end
    end
  end

  assign valid_o  = hi_any | lo_any;
  assign lvl_hi_o = hi_any;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter logic [15:0] VEC_STRIDE  = 16'h0008
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext0_ni,
  input  logic             ext1_ni,
  input  logic             tmr0_ovf_i,
  input  logic             tmr1_ovf_i,
  input  logic             ser_rx_i,
  input  logic             ser_tx_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  input  logic             irq_ack_i,
  input  logic             irq_ret_i
);
  localparam int NEXT = 2;
  localparam logic [7:0] EN_MASK = 8'h80 | 8'((1 << NSRC) - 1);

  logic [7:0]      en_q;
  logic [NSRC-1:0] prio_q;
  logic [NEXT-1:0] mode_q, ext_flag, ext_pin;
  logic [1:0]      tf_q, tmr_ovf;
  logic            rx_q, tx_q;
  isr_t            isr_q, isr_d;

  logic [NSRC-1:0]  flags, req, grant;
  logic             win_valid, win_hi, ack_fire;
  logic [IDX_W-1:0] win_idx;
  logic             pend_we;

  assign pend_we  = reg_we_i && reg_addr_i == ADDR_PEND;
  assign ack_fire = irq_ack_i && win_valid;
  assign ext_pin  = {ext1_ni, ext0_ni};
  assign tmr_ovf  = {tmr1_ovf_i, tmr0_ovf_i};

  localparam int EXT_IDX [NEXT] = '{int'(SRC_EXT0), int'(SRC_EXT1)};
  localparam int TMR_IDX [2]    = '{int'(SRC_TMR0), int'(SRC_TMR1)};

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    irq_ext_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_ni     (ext_pin[g]),
      .edge_mode_i(mode_q[g]),
      .clr_i      (ack_fire && grant[EXT_IDX[g]]),
      .sw_we_i    (pend_we),
      .sw_val_i   (reg_wdata_i[EXT_IDX[g]]),
      .flag_o     (ext_flag[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tf_q[g] <= 1'b0;
      else if (pend_we) tf_q[g] <= reg_wdata_i[TMR_IDX[g]];
      else              tf_q[g] <= (tf_q[g] & ~(ack_fire & grant[TMR_IDX[g]])) | tmr_ovf[g];
    end
  end

  // serial flags are software-cleared only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else if (pend_we) begin
      rx_q <= reg_wdata_i[NSRC-1];
      tx_q <= reg_wdata_i[NSRC];
    end else begin
      rx_q <= rx_q | ser_rx_i;
      tx_q <= tx_q | ser_tx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
      mode_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_MODE: mode_q <= reg_wdata_i[NEXT-1:0];
        ADDR_EN:   en_q   <= reg_wdata_i & EN_MASK;
        ADDR_PRIO: prio_q <= reg_wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
  end

  assign flags = {rx_q | tx_q, tf_q[1], ext_flag[1], tf_q[0], ext_flag[0]};
  assign req   = flags & en_q[NSRC-1:0] & {NSRC{en_q[EN_GLOBAL]}};

  irq_arbiter u_arb (
    .req_i   (req),
    .prio_i  (prio_q),
    .isr_i   (isr_q),
    .valid_o (win_valid),
    .lvl_hi_o(win_hi),
    .idx_o   (win_idx),
    .grant_o (grant)
  );

  // return releases the highest active level, then acknowledge claims
  always_comb begin
    isr_d = isr_q;
    if (irq_ret_i) begin
      if (isr_q.hi) isr_d.hi = 1'b0;
      else          isr_d.lo = 1'b0;
    end
    if (ack_fire) begin
      if (win_hi) isr_d.hi = 1'b1;
      else        isr_d.lo = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign irq_req_o = win_valid;
  assign irq_vec_o = VEC_W'(VEC_BASE + VEC_STRIDE * 16'(win_idx));

  always_comb begin
    case (reg_addr_i)
      ADDR_PEND: reg_rdata_o = {2'b00, tx_q, rx_q, tf_q[1], ext_flag[1], tf_q[0], ext_flag[0]};
      ADDR_MODE: reg_rdata_o = 8'(mode_q);
      ADDR_EN:   reg_rdata_o = en_q;
      default:   reg_rdata_o = 8'(prio_q);
    endcase
  end

  // R8
  ea_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[EN_GLOBAL] |-> !irq_req_o);
  // R11
  hi_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_q.hi |-> !irq_req_o);
  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (win_valid == (grant != '0)));
  // R12
  ret_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !ack_fire && isr_q.hi) |=> (!isr_q.hi && isr_q.lo == $past(isr_q.lo)));
  // R5
  tmr0_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && grant[SRC_TMR0] && !tmr0_ovf_i && !pend_we) |=> !tf_q[0]);
  // R6
  ser_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && grant[SRC_SER] && !pend_we) |=> (rx_q == $past(rx_q | ser_rx_i)));
  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_EN) |-> (reg_rdata_o[6:5] == 2'b00));
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext0_n = 1'b1, ext1_n = 1'b1, t0 = 1'b0, t1 = 1'b0, rx = 1'b0, tx = 1'b0;
  logic we = 1'b0, ack = 1'b0, ret = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext0_ni(ext0_n), .ext1_ni(ext1_n),
    .tmr0_ovf_i(t0), .tmr1_ovf_i(t1), .ser_rx_i(rx), .ser_tx_i(tx),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(irq), .irq_vec_o(vec), .irq_ack_i(ack), .irq_ret_i(ret)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cpu_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic cpu_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic chk_irq(input string tag, input logic r, input logic [15:0] v);
    chk({tag, " req"}, irq, r);
    if (r) chk({tag, " vec"}, vec, v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 8'h00);
    end
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    rd(2'd2, d);
    chk("R2 enable reserved", d, 8'h9F);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    wr(2'd2, 8'h82);
    @(negedge clk); t0 = 1'b1;
    @(negedge clk); t0 = 1'b0;
    chk_irq("R5 R9 timer0", 1'b1, 16'h000B);
    cpu_ack();
    rd(2'd0, d);
    chk("R5 tf0 cleared", d, 8'h00);
    chk("R5 no req", irq, 1'b0);
    cpu_ret();
  endtask

  task automatic t_gate();
    logic [7:0] d;
    wr(2'd2, 8'h08);
    @(negedge clk); t1 = 1'b1;
    @(negedge clk); t1 = 1'b0;
    chk("R8 global off", irq, 1'b0);
    rd(2'd0, d);
    chk("R8 flag kept", d, 8'h08);
    wr(2'd2, 8'h88);
    chk_irq("R8 R9 timer1", 1'b1, 16'h001B);
    wr(2'd0, 8'h00);
    chk("R7 cancel", irq, 1'b0);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h81);
    @(negedge clk); ext0_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet", irq, 1'b0);
    @(negedge clk);
    chk_irq("R3 R9 ext0", 1'b1, 16'h0003);
    cpu_ack();
    rd(2'd0, d);
    chk("R3 edge cleared", d, 8'h00);
    chk("R3 no req", irq, 1'b0);
    cpu_ret();
    ext0_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(2'd2, 8'h84);
    @(negedge clk); ext1_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_irq("R4 R9 ext1", 1'b1, 16'h0013);
    cpu_ack();
    rd(2'd0, d);
    chk("R4 level kept", d, 8'h04);
    chk("R11 low busy", irq, 1'b0);
    cpu_ret();
    chk_irq("R12 released", 1'b1, 16'h0013);
    ext1_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    chk("R4 follows pin", d, 8'h00);
    chk("R4 no req", irq, 1'b0);
  endtask

  task automatic t_serial();
    logic [7:0] d;
    wr(2'd2, 8'h90);
    @(negedge clk); rx = 1'b1;
    @(negedge clk); rx = 1'b0;
    chk_irq("R6 R9 serial", 1'b1, 16'h0023);
    cpu_ack();
    rd(2'd0, d);
    chk("R6 rx kept", d, 8'h10);
    cpu_ret();
    wr(2'd0, 8'h20);
    chk_irq("R6 R7 tx only", 1'b1, 16'h0023);
    wr(2'd0, 8'h00);
    chk("R7 serial cancel", irq, 1'b0);
  endtask

  task automatic t_poll_nest();
    logic [7:0] d;
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h9F);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h1E);
    chk_irq("R9 poll order", 1'b1, 16'h000B);
    wr(2'd3, 8'h10);
    chk_irq("R10 high wins", 1'b1, 16'h0023);
    cpu_ack();
    chk("R11 high busy", irq, 1'b0);
    cpu_ret();
    chk_irq("R6 serial again", 1'b1, 16'h0023);
    wr(2'd0, 8'h0E);
    wr(2'd3, 8'h08);
    chk_irq("R10 timer1 high", 1'b1, 16'h001B);
    cpu_ack();
    cpu_ret();
    chk_irq("R9 low next", 1'b1, 16'h000B);
    cpu_ack();
    rd(2'd0, d);
    chk("R5 tf0 cleared", d, 8'h04);
    chk("R11 low blocks low", irq, 1'b0);
    wr(2'd0, 8'h0C);
    chk_irq("R11 preempt", 1'b1, 16'h001B);
    cpu_ack();
    chk("R11 nested none", irq, 1'b0);
    cpu_ret();
    chk("R12 low still held", irq, 1'b0);
    cpu_ret();
    chk_irq("R12 low released", 1'b1, 16'h0013);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_timer();
    t_gate();
    t_edge();
    t_level();
    t_serial();
    t_poll_nest();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule